// File: doc/BRIEF.md
# Two-Stage Bark/Bite Watchdog Timer

This block is a memory-mapped watchdog with two stages. While it is enabled, it counts ticks of a slow, always-on time base. The block has one counter and two thresholds, each programmed on its own:

- When the count reaches the first (bark) threshold, the block raises a level interrupt request. Software can then react.
- When the count reaches the second (bite) threshold, the block drives a system reset request.

Software keeps the watchdog quiet by writing a restart register, which returns the count to zero. It starts and stops counting through an enable register. The block can also force a near-immediate reset: program the bite threshold to 1, restart the count, then enable.

All registers sit on a simple synchronous bus clocked by `clk`. The bus has an address, write and read strobes, and write and read data. The slow clock is represented by a one-cycle `tick` qualifier in the same clock domain. Widths are parameters: the count width (28 bits by default, giving up to 2^28 ticks), the bus width, the address width, and the length of the reset pulse.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset, `bark_irq` and `bite_rst_req` are low, and the enable, bark-threshold and bite-threshold registers read as zero.
- R2: The enable register returns bit 0 of the last value written to it. Both threshold registers return the low CNT_W bits of the last value written. All other read bits are zero.
- R3: The register byte offsets are: restart 0x04, enable 0x08, bark threshold 0x10, bite threshold 0x14. The restart register reads as zero. Any other offset reads as zero, and writes to it change no register.
- R4: A write of bit 0 = 1 to the restart register returns the count to zero and drops `bark_irq`, two clock cycles after the write. Counting then restarts from zero. A write with bit 0 = 0 has no effect.
- R5: Each enabled tick adds one to the count, which saturates at its all-ones value. `bark_irq` rises on the clock after the tick whose new count is greater than or equal to the bark threshold. A threshold of 0 or 1 therefore fires on the first enabled tick.
- R6: `bark_irq` stays high until a restart or until the enable register holds 0.
- R7: While the enable register holds 0, ticks do not advance the count and start no bark or bite. The count is kept, and counting resumes from that value when the block is enabled again.
- R8: On the enabled tick whose new count is greater than or equal to the bite threshold, `bite_rst_req` goes high. It stays high for exactly BITE_HOLD ticks, counting that tick. It then stays low until a restart re-arms it.
- R9: With the bite threshold at 1, a restart followed by enable makes `bite_rst_req` high on the clock after the first tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle qualifier marking a slow time-base tick |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset within the register window |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the cycle that `bus_rd` is high; zero otherwise |
| bark_irq | output | 1 | Level interrupt request from the first stage |
| bite_rst_req | output | 1 | Reset request pulse from the second stage |

## Verification
The bench builds the block with a 6-bit count and a 3-tick reset pulse. At that size every bark threshold from 0 to 61 can be swept, with one check per tick. The bite threshold is swept from 0 to 20, and each run is followed until the pulse ends and the second stage stays quiet. The small count width also makes the 6-bit read-back truncation visible with an all-ones write. The remaining sequences pause enable in the middle of a count, restart while the interrupt is held, and probe unmapped offsets against the real registers.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   localparam logic [7:0] OFS_RESTART = 8'h04;
   localparam logic [7:0] OFS_ENABLE  = 8'h08;
   localparam logic [7:0] OFS_BARK    = 8'h10;
   localparam logic [7:0] OFS_BITE    = 8'h14;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_RESTART,
      SEL_ENABLE,
      SEL_BARK,
      SEL_BITE
   } reg_sel_e;

   function automatic reg_sel_e decode_ofs(input logic [7:0] ofs);
      reg_sel_e sel;
      case (ofs)
         OFS_RESTART: sel = SEL_RESTART;
         OFS_ENABLE:  sel = SEL_ENABLE;
         OFS_BARK:    sel = SEL_BARK;
         OFS_BITE:    sel = SEL_BITE;
         default:     sel = SEL_NONE;
      endcase
      return sel;
   endfunction

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
   import wdog_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 28
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              en_o,
   output logic              clr_o,
   output logic [CNT_W-1:0]  bark_thr_o,
   output logic [CNT_W-1:0]  bite_thr_o
);

   localparam int PAD_A = 8 - ADDR_W;
   localparam int PAD_D = DATA_W - CNT_W;

   logic [7:0] ofs;
   reg_sel_e   sel;

   generate
      if (PAD_A > 0) begin : g_pad_addr
         assign ofs = {{PAD_A{1'b0}}, bus_addr};
      end else begin : g_full_addr
         assign ofs = bus_addr;
      end
   endgenerate

   assign sel = decode_ofs(ofs);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_o       <= 1'b0;
         clr_o      <= 1'b0;
         bark_thr_o <= '0;
         bite_thr_o <= '0;
      end else begin
         clr_o <= bus_wr && (sel == SEL_RESTART) && bus_wdata[0];
         if (bus_wr && sel == SEL_ENABLE) en_o       <= bus_wdata[0];
         if (bus_wr && sel == SEL_BARK)   bark_thr_o <= bus_wdata[CNT_W-1:0];
         if (bus_wr && sel == SEL_BITE)   bite_thr_o <= bus_wdata[CNT_W-1:0];
      end
   end

   logic [DATA_W-1:0] thr_bark_ext, thr_bite_ext;

   generate
      if (PAD_D > 0) begin : g_pad_data
         assign thr_bark_ext = {{PAD_D{1'b0}}, bark_thr_o};
         assign thr_bite_ext = {{PAD_D{1'b0}}, bite_thr_o};
         logic unused_wdata_hi;
         assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CNT_W];
      end else begin : g_full_data
         assign thr_bark_ext = bark_thr_o;
         assign thr_bite_ext = bite_thr_o;
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         case (sel)
            SEL_ENABLE: bus_rdata[0] = en_o;
            SEL_BARK:   bus_rdata    = thr_bark_ext;
            SEL_BITE:   bus_rdata    = thr_bite_ext;
            default:    bus_rdata    = '0;
         endcase
      end
   end

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
   parameter int CNT_W = 28
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             en,
   input  logic             clr,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] next_o,
   output logic             step_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   assign step_o = tick && en && !clr;
   assign next_o = (cnt_o == CNT_MAX) ? CNT_MAX : cnt_o + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_o <= '0;
      else if (clr)    cnt_o <= '0;
      else if (step_o) cnt_o <= next_o;
   end

endmodule

// File: rtl/wdog_stage.sv
module wdog_stage #(
   parameter int CNT_W = 28,
   parameter bit PULSE = 1'b0,
   parameter int HOLD  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             en,
   input  logic             clr,
   input  logic             step,
   input  logic [CNT_W-1:0] next_cnt,
   input  logic [CNT_W-1:0] thr,
   output logic             fire_o
);

   localparam int HOLD_W = $clog2(HOLD + 1);

   logic hit;
   assign hit = step && (next_cnt >= thr);

   generate
      if (!PULSE) begin : g_level
         logic unused_tick;
         assign unused_tick = tick;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          fire_o <= 1'b0;
            else if (clr || !en) fire_o <= 1'b0;
            else if (hit)        fire_o <= 1'b1;
         end
      end else begin : g_pulse
         logic              unused_en;
         logic              fired_q;
         logic [HOLD_W-1:0] left_q;
         assign unused_en = en;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               fired_q <= 1'b0;
               left_q  <= '0;
            end else begin
               if (clr)                   fired_q <= 1'b0;
               else if (hit && !fired_q)  fired_q <= 1'b1;
               if (hit && !fired_q)           left_q <= HOLD_W'(HOLD);
               else if (tick && left_q != '0) left_q <= left_q - 1'b1;
            end
         end
         assign fire_o = (left_q != '0);
      end
   endgenerate

endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage #(
   parameter int ADDR_W    = 6,
   parameter int DATA_W    = 32,
   parameter int CNT_W     = 28,
   parameter int BITE_HOLD = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bark_irq,
   output logic              bite_rst_req
);

   generate
      if (ADDR_W < 5 || ADDR_W > 8) begin : g_bad_addr
         $error("wdog_two_stage: ADDR_W must be 5..8");
      end
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("wdog_two_stage: CNT_W must be 2..DATA_W");
      end
      if (BITE_HOLD < 1) begin : g_bad_hold
         $error("wdog_two_stage: BITE_HOLD must be at least 1");
      end
   endgenerate

   logic             en_q, clr_q, step;
   logic [CNT_W-1:0] bark_thr, bite_thr, cnt_q, cnt_next;

   wdog_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .en_o(en_q), .clr_o(clr_q), .bark_thr_o(bark_thr), .bite_thr_o(bite_thr)
   );

   wdog_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .en(en_q), .clr(clr_q),
      .cnt_o(cnt_q), .next_o(cnt_next), .step_o(step)
   );

   wdog_stage #(.CNT_W(CNT_W), .PULSE(1'b0), .HOLD(BITE_HOLD)) u_bark (
      .clk(clk), .rst_n(rst_n), .tick(tick), .en(en_q), .clr(clr_q),
      .step(step), .next_cnt(cnt_next), .thr(bark_thr), .fire_o(bark_irq)
   );

   wdog_stage #(.CNT_W(CNT_W), .PULSE(1'b1), .HOLD(BITE_HOLD)) u_bite (
      .clk(clk), .rst_n(rst_n), .tick(tick), .en(en_q), .clr(clr_q),
      .step(step), .next_cnt(cnt_next), .thr(bite_thr), .fire_o(bite_rst_req)
   );

endmodule

// File: rtl/wdog_two_stage_chk.sv
module wdog_two_stage_chk #(
   parameter int CNT_W = 28
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic             en,
   input logic             clr,
   input logic [CNT_W-1:0] cnt,
   input logic             bark_irq,
   input logic             bite_rst_req
);

   p_restart_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0 && !bark_irq));

   p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != '0 && !clr) |=> (cnt != '0));

   p_bark_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bark_irq && en && !clr) |=> bark_irq);

   p_frozen_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !clr) |=> $stable(cnt));

   p_bite_needs_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bite_rst_req) |-> $past(en && tick));

   p_bite_ends_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bite_rst_req) |-> $past(tick));

endmodule

bind wdog_two_stage wdog_two_stage_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .en(en_q), .clr(clr_q),
   .cnt(cnt_q), .bark_irq(bark_irq), .bite_rst_req(bite_rst_req)
);

// File: tb/wdog_two_stage_tb.sv
`timescale 1ns/1ps
module wdog_two_stage_tb;

   localparam int AW = 6, DW = 32, CW = 6, HOLD = 3;
   localparam logic [AW-1:0] A_RST = 6'h04, A_EN = 6'h08, A_BARK = 6'h10, A_BITE = 6'h14;

   logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0, bus_rdata;
   logic bark_irq, bite_rst_req;
   int n_chk = 0, n_fail = 0;

   always #10 clk = ~clk;

   wdog_two_stage #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW), .BITE_HOLD(HOLD)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bark_irq(bark_irq), .bite_rst_req(bite_rst_req)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
      @(negedge clk); bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      bus_rd = 1'b0;
   endtask

   task automatic tk();
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
   endtask

   task automatic idle();
      @(negedge clk);
   endtask

   task automatic restart();
      wr(A_RST, 1); idle();
   endtask

   logic [DW-1:0] v;

   initial begin
      #(20ns * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 irq", bark_irq, 0);
      chk("R1 rst", bite_rst_req, 0);
      rd(A_EN, v);   chk("R1 en", v, 0);
      rd(A_BARK, v); chk("R1 bark", v, 0);
      rd(A_BITE, v); chk("R1 bite", v, 0);

      // R2 read-back with truncation
      wr(A_BARK, 32'hFFFF_FFFF); rd(A_BARK, v); chk("R2 bark trunc", v, 32'h3F);
      wr(A_BITE, 32'h2A);        rd(A_BITE, v); chk("R2 bite", v, 32'h2A);
      wr(A_EN, 32'h3);           rd(A_EN, v);   chk("R2 en bit0", v, 1);
      wr(A_EN, 32'h2);           rd(A_EN, v);   chk("R2 en clear", v, 0);

      // R3 unmapped offsets and restart register read
      wr(6'h0C, '1); wr(6'h3C, '1); wr(6'h11, '1); wr(6'h00, '1);
      rd(6'h0C, v); chk("R3 unmapped 0x0C", v, 0);
      rd(6'h3C, v); chk("R3 unmapped 0x3C", v, 0);
      rd(6'h11, v); chk("R3 unmapped 0x11", v, 0);
      rd(A_RST, v); chk("R3 restart reads zero", v, 0);
      rd(A_BARK, v); chk("R3 bark untouched", v, 32'h3F);
      rd(A_BITE, v); chk("R3 bite untouched", v, 32'h2A);
      rd(A_EN, v);   chk("R3 en untouched", v, 0);

      // R5 bark sweep: irq after k ticks equals k >= max(B,1)
      for (int b = 0; b <= 61; b++) begin
         int eff;
         eff = (b < 1) ? 1 : b;
         wr(A_EN, 0); wr(A_BARK, b); wr(A_BITE, 63); wr(A_EN, 1);
         restart();
         for (int k = 1; k <= eff + 1; k++) begin
            tk();
            chk($sformatf("R5 bark B=%0d k=%0d", b, k), bark_irq, (k >= eff));
         end
      end

      // R8 bite sweep: high for ticks T'..T'+HOLD-1, then stays low
      for (int t = 0; t <= 20; t++) begin
         int eff;
         eff = (t < 1) ? 1 : t;
         wr(A_EN, 0); wr(A_BARK, 63); wr(A_BITE, t); wr(A_EN, 1);
         restart();
         for (int k = 1; k <= eff + HOLD + 2; k++) begin
            tk();
            chk($sformatf("R8 bite T=%0d k=%0d", t, k), bite_rst_req,
                (k >= eff) && (k < eff + HOLD));
         end
      end

      // R7 pause keeps the count; R6 level hold
      wr(A_EN, 0); wr(A_BARK, 5); wr(A_BITE, 63); wr(A_EN, 1);
      restart();
      repeat (3) tk();
      chk("R5 below threshold", bark_irq, 0);
      wr(A_EN, 0);
      repeat (10) tk();
      chk("R7 no bark while off", bark_irq, 0);
      wr(A_EN, 1);
      tk(); chk("R7 resumed count 4", bark_irq, 0);
      tk(); chk("R7 resumed count 5", bark_irq, 1);
      repeat (5) tk();
      chk("R6 irq held", bark_irq, 1);
      wr(A_RST, 0); idle(); idle();
      chk("R4 restart bit0=0 ignored", bark_irq, 1);
      wr(A_EN, 0);
      chk("R6 irq one cycle after disable", bark_irq, 1);
      idle();
      chk("R6 irq dropped by disable", bark_irq, 0);
      wr(A_EN, 1);
      tk(); chk("R6 irq back on tick", bark_irq, 1);
      wr(A_RST, 1);
      chk("R4 irq one cycle after restart", bark_irq, 1);
      idle();
      chk("R4 irq dropped by restart", bark_irq, 0);
      repeat (4) tk();
      chk("R4 count restarted", bark_irq, 0);
      tk(); chk("R4 fires after 5 fresh ticks", bark_irq, 1);

      // R7 bite suppressed while off
      wr(A_EN, 0); wr(A_BARK, 63); wr(A_BITE, 2);
      restart();
      for (int k = 1; k <= 5; k++) begin
         tk(); chk($sformatf("R7 no bite while off k=%0d", k), bite_rst_req, 0);
      end

      // R9 immediate bite path
      wr(A_BITE, 1); restart(); wr(A_EN, 1);
      chk("R9 before tick", bite_rst_req, 0);
      tk(); chk("R9 bite after one tick", bite_rst_req, 1);
      repeat (HOLD) tk();
      chk("R8 pulse over", bite_rst_req, 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule